// File: doc/BRIEF.md
# Address Decoder with Per-Window Fault Bridge

This block sits between a processor-side request port and a set of target devices. Each request address is compared against a table of mapping entries, each with a base, a size and a target number. An access that lands in an entry goes out on the target side in the same cycle. An entry flagged for translation rebases the address before it is forwarded. The target's read data and error flag are folded into a response that is registered for one cycle.

Accesses that match no entry are first checked against a second table of bridge windows. A window covers a span of the address space that may contain holes between mapped entries. A read that falls into such a hole returns the window's configured status and default data. A side-effect-free probe (inquiry) returns all ones. Each window holds a small status record of the first fault it saw: a hole access or a target error inside the window. The record keeps the address, the direction and a cause code, and has a sticky flag that software clears by writing one to it. Addresses outside every window get a plain "not taken" status with zero data and leave no record.

Top module: `addr_dec_bridge`

## Requirements
- R1: When a request matches a mapping entry, `tgt_valid` is high in the same cycle and `tgt_sel` carries that entry's target number. Where entries overlap, the lowest-numbered entry is used. Default table: entry 0 is 0x0000–0x0FFF to target 0, entry 1 is 0x2000–0x27FF to target 1, entry 2 is 0x4000–0x40FF to target 2, and entry 3 is 0x0800–0x17FF to target 3.
- R2: An entry without translation forwards the address unchanged. A translating entry forwards address − base + offset. By default only entry 2 translates, with offset 0x0040.
- R3: One cycle after a mapped request, the response carries status 0 (OK), or status 2 (target error) if `tgt_err` was high. `resp_rdata` holds the target read data for reads and zero for writes.
- R4: A request that hits neither an entry nor a window gets status 1 (not taken) and zero data one cycle later. No target access is made and no window record changes.
- R5: A non-inquiry request in a window but outside every entry gets that window's status. A read gets the window's default data and a write gets zero. Window 0 spans 0x2000–0x3FFF with status 0 and data 0xBEEF. Window 1 spans 0x4000–0x7FFF with status 1 and data 0x0BAD.
- R6: An inquiry request (`req_inq`=1) to a hole inside a window returns the window's status with data all ones. No inquiry ever changes a window record.
- R7: The first fault in a window with a clear sticky flag sets the flag and records the address, the write bit and the cause code: 1 for a hole and 2 for a target error. While the flag stays set, later faults leave the record unchanged.
- R8: A target error on a mapped address that lies inside a window is recorded in that window with cause 2.
- R9: A one in bit w of `clr_mask` clears the sticky flag of window w at the next edge. If a fault for that window arrives in the same cycle, the new fault is recorded and the flag stays set.
- R10: After reset, `resp_valid` is 0 and every window record (flag, address, write bit, code) is 0.
- R11: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_inq | input | 1 | Side-effect-free inquiry |
| req_wdata | input | DW | Write data |
| tgt_valid | output | 1 | Forwarded access to a target |
| tgt_sel | output | TW | Selected target number |
| tgt_addr | output | AW | Forwarded (possibly translated) address |
| tgt_write | output | 1 | Forwarded direction |
| tgt_wdata | output | DW | Forwarded write data |
| tgt_rdata | input | DW | Target read data, same cycle |
| tgt_err | input | 1 | Target error, same cycle |
| resp_valid | output | 1 | Response present |
| resp_status | output | 2 | 0 OK, 1 not taken, 2 target error |
| resp_rdata | output | DW | Response read data |
| clr_mask | input | NW | Write-one-to-clear of window sticky flags |
| bst_sticky | output | NW | Per-window sticky fault flag |
| bst_addr | output | NW*AW | Per-window recorded address |
| bst_write | output | NW | Per-window recorded direction |
| bst_code | output | NW*2 | Per-window recorded cause |

## Verification
The target-side outputs are combinational, so the bench checks them one time unit after it drives a request on a falling edge. The response and the window records pass through one register, so they are due at the next rising edge, and the bench samples them at the falling edge that follows. Clear requests are given in cycles of their own and together with faults, and the records are compared against a bench model after each of those edges. A cycle with no request checks that `resp_valid` has gone low again.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
    typedef enum logic [1:0] {
        RSP_OK        = 2'd0,
        RSP_NOT_TAKEN = 2'd1,
        RSP_TGT_ERR   = 2'd2
    } rsp_e;

    localparam logic [1:0] CODE_NONE = 2'd0;
    localparam logic [1:0] CODE_HOLE = 2'd1;
    localparam logic [1:0] CODE_TGT  = 2'd2;
endpackage

// File: rtl/addr_dec_lookup.sv
// Range finder: one modular compare per entry, lowest index wins.
module addr_dec_lookup #(
    parameter int AW = 16,
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1,
    parameter logic [N*AW-1:0] BASES = '0,
    parameter logic [N*AW-1:0] SIZES = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [N-1:0] match;

    generate
        for (genvar g = 0; g < N; g++) begin : g_ent
            logic [AW-1:0] rel;
            assign rel      = addr - BASES[g*AW +: AW];
            assign match[g] = rel < SIZES[g*AW +: AW];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
        hit = |match;
    end
endmodule

// File: rtl/addr_dec_xlate.sv
// Picks target number and forwarded address for the winning entry.
module addr_dec_xlate #(
    parameter int AW = 16,
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1,
    parameter int TW = 2,
    parameter logic [N*AW-1:0] BASES = '0,
    parameter logic [N*AW-1:0] OFFS  = '0,
    parameter logic [N-1:0]    XLATE = '0,
    parameter logic [N*TW-1:0] TGTS  = '0
) (
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] fwd,
    output logic [TW-1:0] sel
);
    always_comb begin
        fwd = addr;
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (idx == IW'(i)) begin
                sel = TGTS[i*TW +: TW];
                if (XLATE[i]) fwd = addr - BASES[i*AW +: AW] + OFFS[i*AW +: AW];
            end
        end
    end
endmodule

// File: rtl/addr_dec_bridge_regs.sv
// One window's first-fault record with write-one-to-clear sticky flag.
module addr_dec_bridge_regs #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev,
    input  logic [AW-1:0] ev_addr,
    input  logic          ev_write,
    input  logic [1:0]    ev_code,
    input  logic          clr,
    output logic          sticky,
    output logic [AW-1:0] rec_addr,
    output logic          rec_write,
    output logic [1:0]    rec_code
);
    import addr_dec_pkg::*;

    typedef struct packed {
        logic          sticky;
        logic [AW-1:0] addr;
        logic          write;
        logic [1:0]    code;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (clr) rec_d.sticky = 1'b0;
        if (ev && (!rec_q.sticky || clr)) begin
            rec_d.sticky = 1'b1;
            rec_d.addr   = ev_addr;
            rec_d.write  = ev_write;
            rec_d.code   = ev_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '{sticky: 1'b0, addr: '0, write: 1'b0, code: CODE_NONE};
        else        rec_q <= rec_d;
    end

    assign sticky    = rec_q.sticky;
    assign rec_addr  = rec_q.addr;
    assign rec_write = rec_q.write;
    assign rec_code  = rec_q.code;

    // R9
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev) |=> !sticky);

    // R7
    first_fault_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clr) |=> ($stable(rec_addr) && $stable(rec_code) && $stable(rec_write)));

    // R7
    fault_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> sticky);
endmodule

// File: rtl/addr_dec_bridge.sv
module addr_dec_bridge #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int NM    = 4,
    parameter int NW    = 2,
    parameter int N_TGT = 4,
    parameter int TW    = (N_TGT > 1) ? $clog2(N_TGT) : 1,
    parameter int MIW   = (NM > 1) ? $clog2(NM) : 1,
    parameter int WIW   = (NW > 1) ? $clog2(NW) : 1,
    parameter logic [NM*AW-1:0] MAP_BASES = {16'h0800, 16'h4000, 16'h2000, 16'h0000},
    parameter logic [NM*AW-1:0] MAP_SIZES = {16'h1000, 16'h0100, 16'h0800, 16'h1000},
    parameter logic [NM*AW-1:0] MAP_OFFS  = {16'h0000, 16'h0040, 16'h0000, 16'h0000},
    parameter logic [NM-1:0]    MAP_XLATE = 4'b0100,
    parameter logic [NM*TW-1:0] MAP_TGTS  = {2'd3, 2'd2, 2'd1, 2'd0},
    parameter logic [NW*AW-1:0] WIN_BASES = {16'h4000, 16'h2000},
    parameter logic [NW*AW-1:0] WIN_SIZES = {16'h4000, 16'h2000},
    parameter logic [NW*2-1:0]  WIN_STATS = {2'd1, 2'd0},
    parameter logic [NW*DW-1:0] WIN_DATAS = {16'h0BAD, 16'hBEEF}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic             req_inq,
    input  logic [DW-1:0]    req_wdata,
    output logic             tgt_valid,
    output logic [TW-1:0]    tgt_sel,
    output logic [AW-1:0]    tgt_addr,
    output logic             tgt_write,
    output logic [DW-1:0]    tgt_wdata,
    input  logic [DW-1:0]    tgt_rdata,
    input  logic             tgt_err,
    output logic             resp_valid,
    output logic [1:0]       resp_status,
    output logic [DW-1:0]    resp_rdata,
    input  logic [NW-1:0]    clr_mask,
    output logic [NW-1:0]    bst_sticky,
    output logic [NW*AW-1:0] bst_addr,
    output logic [NW-1:0]    bst_write,
    output logic [NW*2-1:0]  bst_code
);
    import addr_dec_pkg::*;

    logic           mhit, whit;
    logic [MIW-1:0] midx;
    logic [WIW-1:0] widx;
    logic [AW-1:0]  fwd;
    logic [TW-1:0]  sel;
    logic           fault;
    logic [1:0]     fcode;

    addr_dec_lookup #(.AW(AW), .N(NM), .IW(MIW), .BASES(MAP_BASES), .SIZES(MAP_SIZES))
        u_map (.addr(req_addr), .hit(mhit), .idx(midx));

    addr_dec_lookup #(.AW(AW), .N(NW), .IW(WIW), .BASES(WIN_BASES), .SIZES(WIN_SIZES))
        u_win (.addr(req_addr), .hit(whit), .idx(widx));

    addr_dec_xlate #(.AW(AW), .N(NM), .IW(MIW), .TW(TW), .BASES(MAP_BASES),
                     .OFFS(MAP_OFFS), .XLATE(MAP_XLATE), .TGTS(MAP_TGTS))
        u_xl (.idx(midx), .addr(req_addr), .fwd(fwd), .sel(sel));

    assign tgt_valid = req_valid && mhit;
    assign tgt_sel   = sel;
    assign tgt_addr  = fwd;
    assign tgt_write = req_write;
    assign tgt_wdata = req_wdata;

    assign fault = req_valid && !req_inq && whit && (!mhit || tgt_err);
    assign fcode = mhit ? CODE_TGT : CODE_HOLE;

    typedef struct packed {
        logic          valid;
        rsp_e          status;
        logic [DW-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '{valid: 1'b0, status: RSP_OK, rdata: '0};
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (mhit) begin
                rsp_d.status = tgt_err ? RSP_TGT_ERR : RSP_OK;
                rsp_d.rdata  = req_write ? '0 : tgt_rdata;
            end else if (whit) begin
                rsp_d.status = rsp_e'(WIN_STATS[int'(widx)*2 +: 2]);
                if (req_inq)        rsp_d.rdata = '1;
                else if (req_write) rsp_d.rdata = '0;
                else                rsp_d.rdata = WIN_DATAS[int'(widx)*DW +: DW];
            end else begin
                rsp_d.status = RSP_NOT_TAKEN;
                rsp_d.rdata  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '{valid: 1'b0, status: RSP_OK, rdata: '0};
        else        rsp_q <= rsp_d;
    end

    assign resp_valid  = rsp_q.valid;
    assign resp_status = rsp_q.status;
    assign resp_rdata  = rsp_q.rdata;

    generate
        for (genvar w = 0; w < NW; w++) begin : g_brg
            addr_dec_bridge_regs #(.AW(AW)) u_regs (
                .clk      (clk),
                .rst_n    (rst_n),
                .ev       (fault && (widx == WIW'(w))),
                .ev_addr  (req_addr),
                .ev_write (req_write),
                .ev_code  (fcode),
                .clr      (clr_mask[w]),
                .sticky   (bst_sticky[w]),
                .rec_addr (bst_addr[w*AW +: AW]),
                .rec_write(bst_write[w]),
                .rec_code (bst_code[w*2 +: 2])
            );
        end
    endgenerate

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R11
    no_resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R4
    hole_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mhit && !whit) |=> (resp_status == RSP_NOT_TAKEN && resp_rdata == '0));

    // R3
    mapped_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mhit && !tgt_err) |=> (resp_status == RSP_OK));

    // R6
    inquiry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_inq && bst_sticky == '0 && clr_mask == '0) |=> (bst_sticky == '0));
endmodule

// File: tb/tb_addr_dec_bridge.sv
module tb_addr_dec_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_inq = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        tgt_valid, tgt_write, tgt_err;
    logic [1:0]  tgt_sel;
    logic [15:0] tgt_addr, tgt_wdata, tgt_rdata;
    logic        resp_valid;
    logic [1:0]  resp_status;
    logic [15:0] resp_rdata;
    logic [1:0]  clr_mask = '0;
    logic [1:0]  bst_sticky, bst_write;
    logic [31:0] bst_addr;
    logic [3:0]  bst_code;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // Bench model of the window records
    logic        m_sticky [2];
    logic [15:0] m_addr [2];
    logic        m_write [2];
    logic [1:0]  m_code [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Target model: data derived from address and target, error on low nibble F
    always_comb begin
        tgt_rdata = tgt_addr ^ {tgt_sel, 14'h0155};
        tgt_err   = (tgt_addr[3:0] == 4'hF);
    end

    addr_dec_bridge dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_inq(req_inq), .req_wdata(req_wdata),
        .tgt_valid(tgt_valid), .tgt_sel(tgt_sel), .tgt_addr(tgt_addr),
        .tgt_write(tgt_write), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
        .tgt_err(tgt_err), .resp_valid(resp_valid), .resp_status(resp_status),
        .resp_rdata(resp_rdata), .clr_mask(clr_mask), .bst_sticky(bst_sticky),
        .bst_addr(bst_addr), .bst_write(bst_write), .bst_code(bst_code)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Reference decode (R1, R2)
    task automatic ref_map(input logic [15:0] a, output logic hit, output logic [1:0] sel, output logic [15:0] fwd);
        hit = 1'b1; fwd = a;
        if (a < 16'h1000)                        sel = 2'd0;
        else if (a >= 16'h2000 && a < 16'h2800)  sel = 2'd1;
        else if (a >= 16'h4000 && a < 16'h4100) begin sel = 2'd2; fwd = a - 16'h4000 + 16'h0040; end
        else if (a >= 16'h0800 && a < 16'h1800)  sel = 2'd3;
        else begin hit = 1'b0; sel = 2'd0; end
    endtask

    task automatic ref_win(input logic [15:0] a, output logic hit, output int w);
        hit = 1'b1; w = 0;
        if (a >= 16'h2000 && a < 16'h4000)      w = 0;
        else if (a >= 16'h4000 && a < 16'h8000) w = 1;
        else hit = 1'b0;
    endtask

    task automatic check_recs(input string rq);
        for (int w = 0; w < 2; w++) begin
            chk(rq, "sticky", 32'(bst_sticky[w]), 32'(m_sticky[w]));
            chk(rq, "rec_addr", 32'(bst_addr[w*16 +: 16]), 32'(m_addr[w]));
            chk(rq, "rec_write", 32'(bst_write[w]), 32'(m_write[w]));
            chk(rq, "rec_code", 32'(bst_code[w*2 +: 2]), 32'(m_code[w]));
        end
    endtask

    task automatic model_update(input logic flt, input int fw, input logic [15:0] a,
                                input logic wr, input logic [1:0] code, input logic [1:0] clr);
        for (int w = 0; w < 2; w++) begin
            logic old;
            old = m_sticky[w];
            if (clr[w]) m_sticky[w] = 1'b0;
            if (flt && fw == w && (!old || clr[w])) begin
                m_sticky[w] = 1'b1; m_addr[w] = a; m_write[w] = wr; m_code[w] = code;
            end
        end
    endtask

    // Called just after a falling edge
    task automatic do_req(input string rq, input logic [15:0] a, input logic wr,
                          input logic inq, input logic [1:0] clr);
        logic mh, wh, err;
        logic [1:0] sel;
        logic [15:0] fwd, edata;
        logic [1:0] estat;
        int w;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_inq = inq;
        req_wdata = a ^ 16'h3C3C; clr_mask = clr;
        ref_map(a, mh, sel, fwd);
        ref_win(a, wh, w);
        #1;
        chk({rq, " R1"}, "tgt_valid", 32'(tgt_valid), 32'(mh));
        err = mh && (fwd[3:0] == 4'hF);
        if (mh) begin
            chk({rq, " R1"}, "tgt_sel", 32'(tgt_sel), 32'(sel));
            chk({rq, " R2"}, "tgt_addr", 32'(tgt_addr), 32'(fwd));
            estat = err ? 2'd2 : 2'd0;
            edata = wr ? 16'h0 : (fwd ^ {sel, 14'h0155});
        end else if (wh) begin
            estat = (w == 1) ? 2'd1 : 2'd0;
            edata = inq ? 16'hFFFF : (wr ? 16'h0 : ((w == 1) ? 16'h0BAD : 16'hBEEF));
        end else begin
            estat = 2'd1; edata = 16'h0;
        end
        model_update(!inq && wh && (!mh || err), w, a, wr, mh ? 2'd2 : 2'd1, clr);
        @(negedge clk);
        req_valid = 1'b0; clr_mask = '0;
        chk({rq, " R11"}, "resp_valid", 32'(resp_valid), 32'd1);
        chk({rq, mh ? " R3" : (wh ? (inq ? " R6" : " R5") : " R4")}, "resp_status", 32'(resp_status), 32'(estat));
        chk({rq, mh ? " R3" : (wh ? (inq ? " R6" : " R5") : " R4")}, "resp_rdata", 32'(resp_rdata), 32'(edata));
        check_recs({rq, " R7"});
    endtask

    task automatic do_clr(input string rq, input logic [1:0] clr);
        clr_mask = clr;
        model_update(1'b0, 0, 16'h0, 1'b0, 2'd0, clr);
        @(negedge clk);
        clr_mask = '0;
        chk({rq, " R11"}, "resp_valid idle", 32'(resp_valid), 32'd0);
        check_recs({rq, " R9"});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int w = 0; w < 2; w++) begin
            m_sticky[w] = 0; m_addr[w] = 0; m_write[w] = 0; m_code[w] = 0;
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "resp_valid", 32'(resp_valid), 32'd0);
        check_recs("R10");
        rst_n = 1'b1;
        @(negedge clk);

        do_req("R1 overlap low wins", 16'h0800, 1'b0, 1'b0, 2'b00);
        do_req("R1 upper overlap", 16'h1000, 1'b0, 1'b0, 2'b00);
        do_req("R2 translate", 16'h4010, 1'b0, 1'b0, 2'b00);
        do_req("R3 write mapped", 16'h2004, 1'b1, 1'b0, 2'b00);
        do_req("R4 outside all", 16'h1800, 1'b0, 1'b0, 2'b00);
        do_req("R4 high outside", 16'hFFFF, 1'b1, 1'b0, 2'b00);
        do_req("R6 inquiry hole", 16'h5000, 1'b0, 1'b1, 2'b00);
        do_req("R5 hole read win0", 16'h3000, 1'b0, 1'b0, 2'b00);
        do_req("R7 second fault held", 16'h3004, 1'b1, 1'b0, 2'b00);
        do_req("R8 R9 tgt err with clear", 16'h200F, 1'b0, 1'b0, 2'b01);
        do_req("R5 hole write win1", 16'h7FFE, 1'b1, 1'b0, 2'b00);
        do_req("R3 mapped err outside win", 16'h000F, 1'b0, 1'b0, 2'b00);
        do_clr("R9 clear both", 2'b11);
        do_req("R11 next", 16'h40FF, 1'b0, 1'b0, 2'b00);
        do_clr("R9 clear idle", 2'b10);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [1:0] cm;
            int pick;
            pick = int'($urandom_range(0, 3));
            case (pick)
                0: a = 16'($urandom);
                1: a = 16'h2000 + 16'($urandom_range(0, 16'h1FFF));
                2: a = 16'h4000 + 16'($urandom_range(0, 16'h01FF));
                default: a = 16'($urandom_range(0, 16'h1FFF));
            endcase
            cm = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
            do_req("random", a, 1'($urandom), ($urandom_range(0, 7) == 0), cm);
            if ($urandom_range(0, 9) == 0) do_clr("random clear", 2'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule